// File: doc/BRIEF.md
# Hierarchical Full-Word Value Cache Bus Encoder

This block sits at the sending end of a wide parallel data bus and lowers the number of wires that switch per transfer. It keeps a stack of value caches. Every level holds complete bus words, and each level further from the top has more entries. An accepted word is looked up in all levels at the same time. When the word is already cached, the bus does not carry the word itself. Instead, a small set of wires is flipped to name the entry, and the control line of the matching level is flipped. When no level holds the word, the raw word is driven, a separate miss line is flipped, and the word enters the top level. Entries pushed out of one level drop into the next level down.

The bus is transition coded. A hit at level k flips exactly k wires of the previously driven value. The bus is cut into k equal segments for this purpose, and one wire flips in each segment. Which wire flips in a segment gives one digit of the entry index. Depth, bus width and the entry limit per level are parameters, so a narrow, shallow instance can be checked in full while a wide one keeps the same structure.

Top module: `hvc_encoder`

## Requirements
- R1: While reset is asserted and directly after it, `bus_out`, `lvl_ctl` and `miss_ctl` are all zero and every level is empty.
- R2: When an accepted word is found in no level, `bus_out` shows that word after the next clock edge. `miss_ctl` flips and no `lvl_ctl` bit changes.
- R3: When an accepted word is found, the uppermost (lowest-numbered) level that holds it is used. For a hit at level k (1-based), exactly k bits of `bus_out` flip, only `lvl_ctl[k-1]` flips, and `miss_ctl` holds.
- R4: For a level-k hit, let S = DW/k (rounded down). Segment j covers bits j*S to j*S+S-1, for j from 0 to k-1. The wire flipped in segment j sits at offset d_j, where d_j is digit j (least significant first) of the entry index written in base S.
- R5: A word that misses everywhere is written into level 1. The entry it replaces, if that entry was occupied, moves into level 2, and so on down the levels. A word displaced from the last level is dropped. A word is therefore held in at most one level.
- R6: Each level replaces its least recently used entry. An entry counts as used when it is written or hit. Unused entries count as older than used ones, and among unused entries the highest index is replaced first.
- R7: A hit marks only the hit entry of that level as most recently used. The word stays in its level, and no other level changes.
- R8: A cycle with `in_valid` low changes neither the outputs nor any cache contents.
- R9: Outputs are registered. An accepted word affects the outputs only after the clock edge at which it is sampled.
- R10: Level k holds min((DW/k)^k, MAX_ENTRIES) entries. With the defaults (DW=12, LEVELS=3), the levels hold 12, 36 and 64 entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Word on `in_data` is to be sent this cycle |
| in_data | input | DW | Word to transmit |
| bus_out | output | DW | Registered transition-coded bus value |
| lvl_ctl | output | LEVELS | Per-level hit lines; bit k-1 flips for a level-k hit |
| miss_ctl | output | 1 | Flips when the raw word is driven |

## Verification
Several properties are checked on every cycle by assertions. A miss puts the raw word on the bus and flips the miss line. A level-k hit flips exactly k bus wires and that level's own line. Idle cycles hold all outputs. The selected level is the uppermost one that hits. Inside each level, the ages always form a permutation, so there is exactly one victim, and no word is held twice.

Other behaviour can only be shown by the bench scenarios, which compare against a model of the caches. These cover the exact wire chosen in each segment and where a word moves as it falls through the levels. They also cover the least-recently-used order after a refresh, and the moment a word drops off the last level and misses again.

// File: rtl/hvc_pkg.sv
package hvc_pkg;

  // Entries of level lvl (1-based): (dw/lvl)^lvl, clipped to lim.
  function automatic int level_entries(int dw, int lvl, int lim);
    int s;
    int p;
    s = dw / lvl;
    p = 1;
    for (int i = 0; i < lvl; i++) begin
      p = p * s;
      if (p >= lim) return lim;
    end
    return (p < 1) ? 1 : p;
  endfunction

  function automatic int idx_width(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Index width wide enough for the largest level.
  function automatic int widest_index(int dw, int levels, int lim);
    int w;
    w = 1;
    for (int k = 1; k <= levels; k++)
      if (idx_width(level_entries(dw, k, lim)) > w)
        w = idx_width(level_entries(dw, k, lim));
    return w;
  endfunction

endpackage

// File: rtl/hvc_level.sv
module hvc_level #(
  parameter int DW = 12,
  parameter int N  = 12,
  parameter int IW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] look_word,
  input  logic          touch,
  input  logic          ins_en,
  input  logic [DW-1:0] ins_word,
  output logic          hit,
  output logic [IW-1:0] hit_idx,
  output logic          evict_valid,
  output logic [DW-1:0] evict_word
);
  localparam int AW = hvc_pkg::idx_width(N);

  logic [DW-1:0] mem [N];
  logic [AW-1:0] age [N];
  logic [N-1:0]  vld;
  logic [N-1:0]  match;
  logic [N-1:0]  oldest;
  logic [AW-1:0] hit_loc;
  logic [AW-1:0] victim;
  logic [AW-1:0] tgt;

  always_comb begin
    hit_loc = '0;
    victim  = '0;
    for (int j = 0; j < N; j++) begin
      match[j]  = vld[j] && (mem[j] == look_word);
      oldest[j] = (age[j] == AW'(N - 1));
      if (match[j])  hit_loc = AW'(j);
      if (oldest[j]) victim  = AW'(j);
    end
  end

  assign hit         = |match;
  assign hit_idx     = IW'(hit_loc);
  assign evict_valid = vld[victim];
  assign evict_word  = mem[victim];
  assign tgt         = ins_en ? victim : hit_loc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
      for (int j = 0; j < N; j++) begin
        mem[j] <= '0;
        age[j] <= AW'(j);
      end
    end else if (touch || ins_en) begin
      for (int j = 0; j < N; j++) begin
        if (AW'(j) == tgt)        age[j] <= '0;
        else if (age[j] < age[tgt]) age[j] <= age[j] + 1'b1;
      end
      if (ins_en) begin
        mem[tgt] <= ins_word;
        vld[tgt] <= 1'b1;
      end
    end
  end

  // Ages stay a permutation, so exactly one replacement candidate exists.
  assert_victim_unique_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(oldest));
  // A word is never held twice in one level.
  assert_single_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));
  // A level is either refreshed or filled in a cycle, never both.
  assert_touch_or_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(touch && ins_en));
  // Only a hitting level may be refreshed.
  assert_touch_needs_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    touch |-> hit);

endmodule

// File: rtl/hvc_prio.sv
module hvc_prio #(
  parameter int L = 3
) (
  input  logic [L-1:0] hits,
  output logic [L-1:0] sel,
  output logic         any
);
  always_comb begin
    sel = '0;
    for (int k = L - 1; k >= 0; k--)
      if (hits[k]) sel = L'(1) << k;
  end
  assign any = |hits;

  assert_sel_single_R3: assert final ($onehot0(sel));
endmodule

// File: rtl/hvc_encoder.sv
module hvc_encoder #(
  parameter int DW          = 12,
  parameter int LEVELS      = 3,
  parameter int MAX_ENTRIES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DW-1:0]     in_data,
  output logic [DW-1:0]     bus_out,
  output logic [LEVELS-1:0] lvl_ctl,
  output logic              miss_ctl
);
  localparam int IW = hvc_pkg::widest_index(DW, LEVELS, MAX_ENTRIES);

  // One wire per segment; the offset inside segment j is digit j of idx.
  function automatic logic [DW-1:0] seg_pattern(int lvl, logic [IW-1:0] idx);
    int s;
    int rem;
    logic [DW-1:0] mask;
    s    = DW / lvl;
    rem  = int'(idx);
    mask = '0;
    for (int j = 0; j < LEVELS; j++) begin
      if (j < lvl) begin
        mask = mask | (DW'(1) << (j * s + rem % s));
        rem  = rem / s;
      end
    end
    return mask;
  endfunction

  logic [LEVELS-1:0] hits;
  logic [LEVELS-1:0] sel;
  logic              any_hit;
  logic [IW-1:0]     idx      [LEVELS];
  logic [DW-1:0]     pat      [LEVELS];
  logic [LEVELS-1:0] ins_en;
  logic [DW-1:0]     ins_word [LEVELS];
  logic [LEVELS-1:0] ev_valid;
  logic [DW-1:0]     ev_word  [LEVELS];

  // Named internal events.
  logic              ev_miss;
  logic [LEVELS-1:0] ev_hit;

  assign ev_miss = in_valid && !any_hit;
  assign ev_hit  = in_valid ? sel : '0;

  hvc_prio #(.L(LEVELS)) u_prio (.hits(hits), .sel(sel), .any(any_hit));

  genvar k;
  generate
    for (k = 0; k < LEVELS; k++) begin : g_lvl
      localparam int NK = hvc_pkg::level_entries(DW, k + 1, MAX_ENTRIES);

      if (k == 0) begin : g_head
        assign ins_en[k]   = ev_miss;
        assign ins_word[k] = in_data;
      end else begin : g_tail
        assign ins_en[k]   = ins_en[k-1] && ev_valid[k-1];
        assign ins_word[k] = ev_word[k-1];
      end

      hvc_level #(.DW(DW), .N(NK), .IW(IW)) u_level (
        .clk        (clk),
        .rst_n      (rst_n),
        .look_word  (in_data),
        .touch      (ev_hit[k]),
        .ins_en     (ins_en[k]),
        .ins_word   (ins_word[k]),
        .hit        (hits[k]),
        .hit_idx    (idx[k]),
        .evict_valid(ev_valid[k]),
        .evict_word (ev_word[k])
      );

      assign pat[k] = seg_pattern(k + 1, idx[k]);

      assert_hit_weight_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_hit[k] |=> ($countones(bus_out ^ $past(bus_out)) == k + 1));
      assert_hit_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_hit[k] |=> (lvl_ctl ^ $past(lvl_ctl)) == LEVELS'(1) << k);
      if (k > 0) begin : g_upper
        assert_uppermost_R3: assert property (@(posedge clk) disable iff (!rst_n)
          sel[k] |-> (hits[k-1:0] == '0));
      end
    end
  endgenerate

  logic [DW-1:0]     bus_d;
  logic [LEVELS-1:0] ctl_d;
  logic              miss_d;

  always_comb begin
    bus_d  = bus_out;
    ctl_d  = lvl_ctl;
    miss_d = miss_ctl;
    if (ev_miss) begin
      bus_d  = in_data;
      miss_d = !miss_ctl;
    end else begin
      for (int j = 0; j < LEVELS; j++) begin
        if (ev_hit[j]) begin
          bus_d    = bus_out ^ pat[j];
          ctl_d[j] = !lvl_ctl[j];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_out  <= '0;
      lvl_ctl  <= '0;
      miss_ctl <= 1'b0;
    end else begin
      bus_out  <= bus_d;
      lvl_ctl  <= ctl_d;
      miss_ctl <= miss_d;
    end
  end

  assert_miss_raw_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_miss |=> (bus_out == $past(in_data)) && (miss_ctl != $past(miss_ctl))
                && $stable(lvl_ctl));
  assert_hit_keeps_miss_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && any_hit) |=> $stable(miss_ctl));
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(bus_out) && $stable(lvl_ctl) && $stable(miss_ctl));
  assert_fill_from_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_en != '0) |-> ev_miss);

endmodule

// File: tb/hvc_encoder_test.sv
`timescale 1ns/1ps
module hvc_encoder_test;
  localparam int DW = 12;
  localparam int LV = 3;
  localparam int MAXE = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic [DW-1:0] bus_out;
  logic [LV-1:0] lvl_ctl;
  logic          miss_ctl;

  hvc_encoder #(.DW(DW), .LEVELS(LV), .MAX_ENTRIES(MAXE)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .bus_out(bus_out), .lvl_ctl(lvl_ctl), .miss_ctl(miss_ctl));

  always #2 clk = ~clk;

  int total = 0;
  int bad   = 0;

  // Reference cache model built from the requirements.
  int            cap [LV];
  logic [DW-1:0] mw  [LV][MAXE];
  bit            mv  [LV][MAXE];
  int            ma  [LV][MAXE];
  logic [DW-1:0] exp_bus;
  logic [LV-1:0] exp_ctl;
  logic          exp_miss;
  int            fresh = 0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic model_clear();
    for (int l = 0; l < LV; l++) begin
      int s, p;
      s = DW / (l + 1);
      p = 1;
      for (int i = 0; i <= l; i++) p = p * s;
      cap[l] = (p > MAXE) ? MAXE : p;                     // R10
      for (int e = 0; e < MAXE; e++) begin
        mv[l][e] = 1'b0; mw[l][e] = '0; ma[l][e] = e;
      end
    end
    exp_bus = '0; exp_ctl = '0; exp_miss = 1'b0;
  endtask

  task automatic model_use(input int l, input int t);
    int a;
    a = ma[l][t];
    for (int e = 0; e < cap[l]; e++)
      if (e == t) ma[l][e] = 0;
      else if (ma[l][e] < a) ma[l][e]++;
  endtask

  function automatic int model_oldest(input int l);
    for (int e = 0; e < cap[l]; e++)
      if (ma[l][e] == cap[l] - 1) return e;
    return 0;
  endfunction

  // Returns hit level (1-based) or 0 for a miss; updates the expected outputs.
  task automatic model_step(input logic [DW-1:0] w, output int lvl);
    int idx;
    lvl = 0; idx = 0;
    for (int l = LV - 1; l >= 0; l--)
      for (int e = 0; e < cap[l]; e++)
        if (mv[l][e] && mw[l][e] == w) begin lvl = l + 1; idx = e; end
    if (lvl > 0) begin
      int s, r;
      s = DW / lvl;
      r = idx;
      for (int j = 0; j < lvl; j++) begin
        exp_bus[j * s + (r % s)] = ~exp_bus[j * s + (r % s)];
        r = r / s;
      end
      exp_ctl[lvl-1] = ~exp_ctl[lvl-1];
      model_use(lvl - 1, idx);
    end else begin
      logic [DW-1:0] carry;
      bit            more;
      exp_bus  = w;
      exp_miss = ~exp_miss;
      carry = w;
      more  = 1'b1;
      for (int l = 0; l < LV; l++) begin
        if (more) begin
          int t;
          logic [DW-1:0] out_w;
          bit out_v;
          t     = model_oldest(l);
          out_v = mv[l][t];
          out_w = mw[l][t];
          mw[l][t] = carry;
          mv[l][t] = 1'b1;
          model_use(l, t);
          more  = out_v;
          carry = out_w;
        end
      end
    end
  endtask

  // Sends one word (valid stays high afterwards) and checks the result.
  task automatic push(input logic [DW-1:0] w, input int want, input string req);
    logic [DW-1:0] prev_bus;
    logic [LV-1:0] prev_ctl;
    logic          prev_miss;
    int lvl, got;
    prev_bus = bus_out; prev_ctl = lvl_ctl; prev_miss = miss_ctl;
    in_valid = 1'b1;
    in_data  = w;
    model_step(w, lvl);
    @(negedge clk);
    check(bus_out == exp_bus, {req, "/R4 bus"}, int'(bus_out), int'(exp_bus));
    check(lvl_ctl == exp_ctl && miss_ctl == exp_miss, {req, "/R3 ctl"},
          int'({lvl_ctl, miss_ctl}), int'({exp_ctl, exp_miss}));
    if (lvl > 0)
      check($countones(bus_out ^ prev_bus) == lvl, {req, "/R3 weight"},
            $countones(bus_out ^ prev_bus), lvl);
    if (want >= 0) begin
      got = -1;
      if (miss_ctl != prev_miss) got = 0;
      for (int k = 0; k < LV; k++) if (lvl_ctl[k] != prev_ctl[k]) got = k + 1;
      check(got == want, {req, " level"}, got, want);
    end
  endtask

  function automatic logic [DW-1:0] next_fresh();
    fresh++;
    return DW'(12'h400 + fresh);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check(bus_out == '0 && lvl_ctl == '0 && miss_ctl == 1'b0, "R1 reset outputs",
          int'({bus_out, lvl_ctl, miss_ctl}), 0);
    rst_n = 1'b1;
    model_clear();
  endtask

  task automatic t_miss_hit();
    logic [DW-1:0] w;
    do_reset();
    w = 12'hA5C;
    in_valid = 1'b1;
    in_data  = w;
    #1;
    check(bus_out == '0 && miss_ctl == 1'b0, "R9 no early change", int'(bus_out), 0);
    push(w, 0, "R2 first miss");
    check(bus_out == w, "R2 raw word", int'(bus_out), int'(w));
    push(w, 1, "R3 repeat hits level 1");
    push(w, 1, "R7 second repeat stays level 1");
  endtask

  task automatic t_idle();
    logic [DW-1:0] b;
    logic [LV-1:0] c;
    logic          m;
    do_reset();
    push(12'h123, 0, "R8 setup");
    b = bus_out; c = lvl_ctl; m = miss_ctl;
    in_valid = 1'b0;
    for (int i = 0; i < 4; i++) begin
      in_data = DW'(12'h7F0 + i);
      @(negedge clk);
    end
    check(bus_out == b && lvl_ctl == c && miss_ctl == m, "R8 idle holds",
          int'(bus_out), int'(b));
    push(12'h7F1, 0, "R8 idle word not stored");
    push(12'h123, 1, "R8 earlier word still cached");
  endtask

  task automatic t_fall_through();
    logic [DW-1:0] w0;
    do_reset();
    w0 = next_fresh();
    push(w0, 0, "R5 first");
    for (int i = 0; i < 12; i++) push(next_fresh(), 0, "R5 fill");
    push(w0, 2, "R5 demoted to level 2");
    do_reset();
    w0 = next_fresh();
    push(w0, 0, "R5 first");
    for (int i = 0; i < 48; i++) push(next_fresh(), 0, "R10 fill");
    push(w0, 3, "R10 demoted to level 3");
    do_reset();
    w0 = next_fresh();
    push(w0, 0, "R5 first");
    for (int i = 0; i < 112; i++) push(next_fresh(), -1, "R10 fill");
    push(w0, 0, "R5 dropped off last level");
  endtask

  task automatic t_lru();
    logic [DW-1:0] a, w1;
    do_reset();
    a = next_fresh();
    push(a, 0, "R6 first");
    w1 = next_fresh();
    push(w1, 0, "R6 second");
    for (int i = 0; i < 10; i++) push(next_fresh(), 0, "R6 fill");
    push(a, 1, "R7 refresh");
    push(next_fresh(), 0, "R6 new word");
    push(a, 1, "R6 refreshed word kept");
    push(w1, 2, "R6 least recent evicted");
  endtask

  task automatic t_random();
    do_reset();
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 7) == 0) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      push(DW'($urandom_range(0, 140)), -1, "R4 random stream");
    end
  endtask

  bit done = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_clear();
    t_miss_hit();
    t_idle();
    t_fall_through();
    t_lru();
    t_random();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule